// File: doc/BRIEF.md
# Dual Data Pointer Register Unit

This block keeps two independent 16-bit pointers that an 8-bit microcontroller core uses to address external data memory. One bit of a small control register, the select register, decides which pointer is active. All pointer traffic reaches the active pointer only: byte reads and writes from the special-function-register (SFR) bus, the core's increment command, its 16-bit immediate load, and the 16-bit address output. The external-data move, code-relative read and indirect-jump paths all take their address from that output.

The SFR bus is a plain synchronous register port. Writes take effect at the clock edge where `sfr_we` is high. Read data is combinational from `sfr_addr` and shows the stored state. The select register sits at address A2h, the active pointer's low byte at 82h and its high byte at 83h. No data stream enters or leaves the block, so there is no valid/ready handshake. Every pin is a plain control or data pin, sampled every cycle, and the block never applies back-pressure.

Top module: `dptr_unit`

## Requirements
- R1: Select register bit 0 picks the active pointer (0 = pointer 0, 1 = pointer 1). `ptr_addr` always shows the active pointer, and the inactive pointer keeps its value through every operation.
- R2: After reset both pointers are 0000h, pointer 0 is active, and the select register reads 00h.
- R3: Select register bits 1 and 2 cannot be written and always read as 0.
- R4: Select register bits 7 to 3 and bit 0 read back the value last written to them. Bit 3 serves software as a general-purpose flag.
- R5: A software increment of the select register (read it, add 1, write back) flips only bit 0 and leaves bits 7 to 3, including the flag, unchanged.
- R6: A write to SFR address 82h loads the low byte of the active pointer, and a write to 83h loads its high byte. Reads at those addresses return the same bytes. Any other unmapped address reads 00h, and writes to it change nothing.
- R7: `ptr_inc` adds 1 to the full 16-bit value of the active pointer at the next edge. FFFFh wraps to 0000h, and no flag is raised.
- R8: `ptr_load` writes `ptr_load_val` into the active pointer at the next edge.
- R9: In the same cycle, an SFR byte write to the active pointer takes priority over `ptr_load`, and `ptr_load` takes priority over `ptr_inc`. The losing operations have no effect, and the untouched byte of a byte write holds.
- R10: A write to the select register takes effect at its clock edge. An increment or load issued in that same cycle acts on the pointer that was active before the write, and `ptr_addr` shows the new selection from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_we | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, combinational from `sfr_addr` |
| ptr_inc | input | 1 | Increment the active pointer |
| ptr_load | input | 1 | Load the active pointer with `ptr_load_val` |
| ptr_load_val | input | 16 | Immediate value for a load |
| ptr_addr | output | 16 | Value of the active pointer |

## Verification
The properties place no legality limits on the inputs. Any mix of `ptr_inc`, `ptr_load` and SFR writes in one cycle is defined by the priority rule, so each property guards itself by excluding the higher-priority operations in its antecedent. For example, the increment check applies only when neither a load nor an SFR write occurs in that cycle. The stimulus therefore needs no constraint. It runs directed sequences that collide every pair of operations, including a select write alongside an increment, and then a long random phase over all four kinds of address with overlapping commands.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int unsigned BYTE_W = 8;

  // Which SFR location the bus is addressing
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_SEL  = 2'd1,
    HIT_LO   = 2'd2,
    HIT_HI   = 2'd3
  } sfr_hit_e;
endpackage

// File: rtl/dptr_sfr_decode.sv
module dptr_sfr_decode
  import dptr_pkg::*;
#(
  parameter logic [7:0] ADDR_SEL = 8'hA2,
  parameter logic [7:0] ADDR_LO  = 8'h82,
  parameter logic [7:0] ADDR_HI  = 8'h83
) (
  input  logic [7:0] addr,
  output sfr_hit_e   hit
);
  always_comb begin
    unique case (addr)
      ADDR_SEL: hit = HIT_SEL;
      ADDR_LO:  hit = HIT_LO;
      ADDR_HI:  hit = HIT_HI;
      default:  hit = HIT_NONE;
    endcase
  end
endmodule

// File: rtl/dptr_select_reg.sv
module dptr_select_reg #(
  parameter int unsigned      SEL_W    = 1,
  parameter logic [7:0]       FIXED0_M = 8'h06
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [7:0]       wdata,
  output logic [7:0]       value,
  output logic [SEL_W-1:0] sel
);
  logic [7:0] store_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  store_q <= '0;
    else if (wr) store_q <= wdata & ~FIXED0_M;
  end

  assign value = store_q & ~FIXED0_M;
  assign sel   = store_q[SEL_W-1:0];
endmodule

// File: rtl/dptr_pointer.sv
module dptr_pointer #(
  parameter int unsigned PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wdata,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             inc,
  output logic [PTR_W-1:0] q
);
  localparam int unsigned HI_LSB = PTR_W - 8;

  logic [PTR_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (active) begin
      if (wr_lo || wr_hi) begin
        if (wr_lo) nxt[7:0]            = wdata;
        if (wr_hi) nxt[PTR_W-1:HI_LSB] = wdata;
      end else if (load) begin
        nxt = load_val;
      end else if (inc) begin
        nxt = q + {{(PTR_W-1){1'b0}}, 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/dptr_unit.sv
module dptr_unit
  import dptr_pkg::*;
#(
  parameter int unsigned NUM_PTR  = 2,
  parameter int unsigned PTR_W    = 16,
  parameter logic [7:0]  ADDR_SEL = 8'hA2,
  parameter logic [7:0]  ADDR_LO  = 8'h82,
  parameter logic [7:0]  ADDR_HI  = 8'h83
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       sfr_addr,
  input  logic             sfr_we,
  input  logic [7:0]       sfr_wdata,
  output logic [7:0]       sfr_rdata,
  input  logic             ptr_inc,
  input  logic             ptr_load,
  input  logic [15:0]      ptr_load_val,
  output logic [15:0]      ptr_addr
);
  localparam int unsigned SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;
  localparam int unsigned HI_LSB = PTR_W - BYTE_W;

  sfr_hit_e         hit;
  logic [7:0]       sel_value;
  logic [SEL_W-1:0] sel;
  logic [PTR_W-1:0] ptr_q [NUM_PTR];
  logic [PTR_W-1:0] act_q;

  dptr_sfr_decode #(
    .ADDR_SEL(ADDR_SEL), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
  ) u_dec (
    .addr(sfr_addr), .hit(hit)
  );

  dptr_select_reg #(.SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .wr(sfr_we && hit == HIT_SEL),
    .wdata(sfr_wdata),
    .value(sel_value), .sel(sel)
  );

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    dptr_pointer #(.PTR_W(PTR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .active(sel == SEL_W'(g)),
      .wr_lo(sfr_we && hit == HIT_LO),
      .wr_hi(sfr_we && hit == HIT_HI),
      .wdata(sfr_wdata),
      .load(ptr_load),
      .load_val(ptr_load_val[PTR_W-1:0]),
      .inc(ptr_inc),
      .q(ptr_q[g])
    );
  end

  assign act_q    = ptr_q[sel];
  assign ptr_addr = act_q;

  always_comb begin
    unique case (hit)
      HIT_SEL: sfr_rdata = sel_value;
      HIT_LO:  sfr_rdata = act_q[7:0];
      HIT_HI:  sfr_rdata = act_q[PTR_W-1:HI_LSB];
      default: sfr_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/dptr_unit_chk.sv
module dptr_unit_chk #(
  parameter logic [7:0] ADDR_SEL = 8'hA2,
  parameter logic [7:0] ADDR_LO  = 8'h82
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  sfr_addr,
  input logic        sfr_we,
  input logic [7:0]  sfr_wdata,
  input logic [7:0]  sfr_rdata,
  input logic        ptr_inc,
  input logic        ptr_load,
  input logic [15:0] ptr_load_val,
  input logic [15:0] ptr_addr
);
  a_r3_fixed_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == ADDR_SEL) |-> (sfr_rdata[2:1] == 2'b00));

  a_r4_sel_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr == ADDR_SEL) |=>
      (sfr_addr != ADDR_SEL || sfr_rdata == ($past(sfr_wdata) & 8'hF9)));

  a_r7_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !ptr_load && !sfr_we) |=> (ptr_addr == $past(ptr_addr) + 16'd1));

  a_r8_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_load && !sfr_we) |=> (ptr_addr == $past(ptr_load_val)));

  a_r9_byte_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr == ADDR_LO) |=>
      (ptr_addr[7:0] == $past(sfr_wdata) && ptr_addr[15:8] == $past(ptr_addr[15:8])));

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_inc && !ptr_load && !sfr_we) |=> $stable(ptr_addr));
endmodule

bind dptr_unit dptr_unit_chk #(.ADDR_SEL(ADDR_SEL), .ADDR_LO(ADDR_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
  .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ptr_inc(ptr_inc),
  .ptr_load(ptr_load), .ptr_load_val(ptr_load_val), .ptr_addr(ptr_addr)
);

// File: tb/dptr_unit_bench.sv
`timescale 1ns/1ps
module dptr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        ptr_inc = 1'b0;
  logic        ptr_load = 1'b0;
  logic [15:0] ptr_load_val = 16'h0000;
  logic [15:0] ptr_addr;

  always #4 clk = ~clk;

  dptr_unit u_dptr_unit (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ptr_inc(ptr_inc),
    .ptr_load(ptr_load), .ptr_load_val(ptr_load_val), .ptr_addr(ptr_addr)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int m_ptr [2];
  int m_ctl = 0;

  function automatic int model_read(int a);
    int act = m_ctl & 1;
    if (a == 'hA2) return m_ctl;
    if (a == 'h82) return m_ptr[act] & 'hFF;
    if (a == 'h83) return (m_ptr[act] >> 8) & 'hFF;
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check read data, update model at edge, check pointer after
  task automatic step(string tag, int a, bit we, int wd, bit inc, bit ld, int lv);
    int act, nctl, np;
    sfr_addr = 8'(a); sfr_we = we; sfr_wdata = 8'(wd);
    ptr_inc = inc; ptr_load = ld; ptr_load_val = 16'(lv);
    #1;
    check({tag, " rdata"}, int'(sfr_rdata), model_read(a));
    act  = m_ctl & 1;
    nctl = m_ctl;
    np   = m_ptr[act];
    if (we && a == 'hA2) nctl = wd & 'hF9;
    if (we && a == 'h82)      np = (np & 'hFF00) | (wd & 'hFF);
    else if (we && a == 'h83) np = (np & 'h00FF) | ((wd & 'hFF) << 8);
    else if (ld)              np = lv & 'hFFFF;
    else if (inc)             np = (np + 1) & 'hFFFF;
    @(posedge clk);
    m_ctl = nctl;
    m_ptr[act] = np;
    @(negedge clk);
    check({tag, " ptr_addr"}, int'(ptr_addr), m_ptr[m_ctl & 1]);
  endtask

  task automatic idle(string tag, int a);
    step(tag, a, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_ptr[0] = 0; m_ptr[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    check("R2 reset ptr_addr", int'(ptr_addr), 0);
    idle("R2 reset select", 'hA2);
    idle("R2 reset low", 'h82);
    // R6: byte writes and reads of pointer 0
    step("R6 write low", 'h82, 1, 'h34, 0, 0, 0);
    step("R6 write high", 'h83, 1, 'h12, 0, 0, 0);
    idle("R6 read low", 'h82);
    idle("R6 read high", 'h83);
    // R1: switch to pointer 1, fill it, switch back
    step("R1 select p1", 'hA2, 1, 'h01, 0, 0, 0);
    step("R1 p1 low", 'h82, 1, 'hCD, 0, 0, 0);
    step("R1 p1 high", 'h83, 1, 'hAB, 0, 0, 0);
    step("R1 select p0", 'hA2, 1, 'h00, 0, 0, 0);
    check("R1 p0 kept", int'(ptr_addr), 'h1234);
    // R3/R4: fixed-zero bits and readback
    step("R3 write ff", 'hA2, 1, 'hFF, 0, 0, 0);
    idle("R3 read f9", 'hA2);
    check("R3 value", int'(sfr_rdata), 'hF9);
    step("R4 write a8", 'hA2, 1, 'hA8, 0, 0, 0);
    idle("R4 read a8", 'hA2);
    // R5: read-add-write of the select register toggles bit 0 only
    for (int k = 0; k < 4; k++) begin
      int r;
      sfr_addr = 8'hA2; #1;
      r = int'(sfr_rdata);
      step("R5 increment select", 'hA2, 1, (r + 1) & 'hFF, 0, 0, 0);
      idle("R5 after increment", 'hA2);
      check("R5 flag kept", int'(sfr_rdata) & 'hF8, 'hA8);
      check("R5 bit0 toggled", int'(sfr_rdata) & 1, (k + 1) & 1);
    end
    // R7: increment and wrap
    step("R7 inc", 'h00, 0, 0, 1, 0, 0);
    step("R7 load ffff", 'h00, 0, 0, 0, 1, 'hFFFF);
    step("R7 wrap", 'h00, 0, 0, 1, 0, 0);
    check("R7 wrapped", int'(ptr_addr), 0);
    // R8: load only the active pointer
    step("R8 select p1", 'hA2, 1, 'h01, 0, 0, 0);
    step("R8 load p1", 'h00, 0, 0, 0, 1, 'h5A5A);
    step("R8 select p0", 'hA2, 1, 'h00, 0, 0, 0);
    check("R8 p0 untouched", int'(ptr_addr), 0);
    // R9: priorities
    step("R9 byte beats load", 'h83, 1, 'h77, 1, 1, 'hBEEF);
    step("R9 load beats inc", 'h00, 0, 0, 1, 1, 'h0100);
    check("R9 load value", int'(ptr_addr), 'h0100);
    // R10: select write with same-cycle increment hits old pointer
    step("R10 select and inc", 'hA2, 1, 'h01, 1, 0, 0);
    check("R10 shows p1", int'(ptr_addr), 'h5A5A);
    step("R10 back and load", 'hA2, 1, 'h00, 0, 1, 'h0F0F);
    check("R10 shows p0", int'(ptr_addr), 'h0101);
    // R6: unmapped address
    step("R6 unmapped write", 'h55, 1, 'hEE, 0, 0, 0);
    idle("R6 unmapped read", 'h55);
    // R1: random mix
    for (int n = 0; n < 3000; n++) begin
      int sel_a = $urandom_range(0, 4);
      int a = (sel_a == 0) ? 'hA2 : (sel_a == 1) ? 'h82 : (sel_a == 2) ? 'h83 :
              (sel_a == 3) ? 'h81 : 'h00;
      step("R1 random", a, ($urandom_range(0, 3) == 0), $urandom_range(0, 255),
           ($urandom_range(0, 1) == 1), ($urandom_range(0, 4) == 0),
           ($urandom_range(0, 7) == 0) ? 'hFFFF : $urandom_range(0, 'hFFFF));
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule